// File: doc/BRIEF.md
# Synchronous Serial Slave Port with Select Framing

This block is the receiving end of a four-wire synchronous serial link. An external master drives the serial clock, the data line toward the slave and an active-low select; the block answers on its own data line. Every transfer swaps one byte in each direction, MSB first. The serial clock, incoming data and select are brought into the system clock domain through two-flop synchronizers, and all edges are detected there. For this to work the system clock must run at least four times faster than the serial clock.

Clock polarity sets the idle level of the serial clock. Clock phase decides which edge captures data and which edge shifts it. With phase 0, the select falling edge starts each byte and presents the first outgoing bit before any clock edge arrives. Select must then rise and fall again before another byte can start. With phase 1, select may stay low, and each run of eight clock cycles makes up one byte. Completed bytes go to a receive register, which raises a full flag and, if that flag is still set, an overrun flag. The outgoing byte comes from a holding register that the local side loads. A byte cut short by select rising is thrown away and can raise a mode-fault flag.

Top module: `spi_slave_port`

## Requirements
- R1: A transfer moves 8 bits each way, MSB first. The byte sampled from `mosi_i` appears on `rx_data_o`, and the master sees the transmit byte on `miso_o` bit by bit.
- R2: `cfg_cpol` gives the idle level of `sck_i`. The leading edge leaves the idle level and the trailing edge returns to it. With `cfg_cpha`=0, data is captured on the leading edge and shifted on the trailing edge. With `cfg_cpha`=1 this is reversed. All four combinations exchange bytes correctly.
- R3: With `cfg_cpha`=0, the falling edge of `ss_n_i` loads the transmit byte and starts the byte. Its MSB is on `miso_o` before the first clock edge.
- R4: With `cfg_cpha`=0, after one byte completes, further clock cycles are ignored until `ss_n_i` goes high and then low again. They produce no received byte.
- R5: With `cfg_cpha`=1 and `ss_n_i` held low, consecutive groups of eight clock cycles each form a complete byte.
- R6: `miso_oe_o` is 0 while the synchronized select is high, and it is 0 two cycles after `ss_n_i` has been high. Clock edges while select is high change no state.
- R7: If `ss_n_i` rises after 1 to 7 bits of a byte, the partial byte is discarded and the bit counter returns to 0. The next byte is received intact.
- R8: An aborted byte under R7 sets `modf_o` only when `cfg_fault_en`=1. A pulse on `modf_clr_i` clears `modf_o`.
- R9: A completed byte is written to `rx_data_o` and sets `rx_full_o` when `rx_full_o` was clear. A pulse on `rx_read_i` clears `rx_full_o`.
- R10: A byte that completes while `rx_full_o` is set is dropped. `rx_data_o` keeps its value and `ovr_o` is set. A pulse on `ovr_clr_i` clears `ovr_o`.
- R11: A pulse on `tx_load_i` captures `tx_data_i` into the holding register. A byte that starts without a new load sends the previous holding value again.
- R12: After reset, `miso_oe_o`, `rx_full_o`, `ovr_o` and `modf_o` are 0, and `rx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_fault_en | input | 1 | Allow aborted bytes to set the mode fault |
| sck_i | input | 1 | Serial clock from master |
| mosi_i | input | 1 | Serial data from master |
| ss_n_i | input | 1 | Active-low select |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for miso_o |
| tx_data_i | input | BITS | Next transmit byte |
| tx_load_i | input | 1 | Load strobe for the holding register |
| rx_data_o | output | BITS | Last accepted received byte |
| rx_full_o | output | 1 | Receive register holds an unread byte |
| rx_read_i | input | 1 | Clear strobe for rx_full_o |
| ovr_o | output | 1 | Overrun flag |
| ovr_clr_i | input | 1 | Write-one-to-clear for ovr_o |
| modf_o | output | 1 | Mode fault flag |
| modf_clr_i | input | 1 | Write-one-to-clear for modf_o |

## Verification
Random byte pairs are exchanged in randomly chosen clock modes, with a fresh select frame for every byte. Any mix-up of edge roles or bit order shows up as corrupted data in one direction or the other. Directed frames cover the phase-specific cases:
- back-to-back bytes under one select, which must be rejected for phase 0 and accepted for phase 1;
- clocks sent while deselected;
- select rising after three bits, with fault detection on and off;
- two bytes with no read in between.

Together these separate a correct framing state machine from ones that miss aborts, take in stray clocks, or overwrite unread data.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  // leading edge leaves the idle level, trailing edge returns to it
  function automatic logic pick_lead(input logic cpol, input logic rise, input logic fall);
    return cpol ? fall : rise;
  endfunction

  // phase 0 captures on the leading edge, phase 1 on the trailing edge
  function automatic logic pick_capture(input logic cpha, input logic lead, input logic trail);
    return cpha ? trail : lead;
  endfunction

  function automatic logic pick_launch(input logic cpha, input logic lead, input logic trail);
    return cpha ? lead : trail;
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int  W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_slv_edges.sv
module spi_slv_edges
  import spi_slv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpol,
  input  logic cpha,
  input  logic sck_s,
  input  logic ss_s,
  output logic capture_ev,
  output logic launch_ev,
  output logic ss_fall_ev,
  output logic ss_rise_ev
);
  logic sck_q;
  logic ss_q;
  logic sck_rise;
  logic sck_fall;
  logic lead_ev;
  logic trail_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      ss_q  <= ss_s;
    end
  end

  assign sck_rise   = sck_s & ~sck_q;
  assign sck_fall   = ~sck_s & sck_q;
  assign lead_ev    = pick_lead(cpol, sck_rise, sck_fall);
  assign trail_ev   = pick_lead(~cpol, sck_rise, sck_fall);
  assign capture_ev = pick_capture(cpha, lead_ev, trail_ev);
  assign launch_ev  = pick_launch(cpha, lead_ev, trail_ev);
  assign ss_fall_ev = ss_q & ~ss_s;
  assign ss_rise_ev = ~ss_q & ss_s;
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core #(
  parameter int BITS = 8,
  localparam int CW   = (BITS > 2) ? $clog2(BITS) : 1,
  localparam logic [CW-1:0] LAST = CW'(BITS - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpha,
  input  logic            capture_ev,
  input  logic            launch_ev,
  input  logic            ss_fall_ev,
  input  logic            ss_rise_ev,
  input  logic            mosi_s,
  input  logic [BITS-1:0] tx_word,
  output logic            miso,
  output logic            byte_done_ev,
  output logic [BITS-1:0] byte_val,
  output logic            abort_ev,
  output logic [CW-1:0]   bit_cnt,
  output logic            armed
);
  logic [BITS-1:0] rx_sr;
  logic [BITS-1:0] tx_sr;
  logic            quiet;

  // no serial event is honoured in a cycle where select moves
  assign quiet        = ss_fall_ev | ss_rise_ev;
  assign byte_done_ev = armed & capture_ev & ~quiet & (bit_cnt == LAST);
  assign byte_val     = {rx_sr[BITS-2:0], mosi_s};
  assign abort_ev     = ss_rise_ev & armed & (bit_cnt != '0);
  assign miso         = tx_sr[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else if (ss_rise_ev) begin
      armed   <= 1'b0;
      bit_cnt <= '0;
    end else if (ss_fall_ev) begin
      armed   <= 1'b1;
      bit_cnt <= '0;
      if (!cpha) tx_sr <= tx_word;
    end else if (armed) begin
      if (capture_ev) begin
        rx_sr <= byte_val;
        if (bit_cnt == LAST) begin
          bit_cnt <= '0;
          if (!cpha) armed <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (launch_ev) begin
        if (cpha && bit_cnt == '0) tx_sr <= tx_word;
        else                       tx_sr <= {tx_sr[BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int BITS = 8,
  localparam int CW  = (BITS > 2) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_fault_en,
  input  logic            sck_i,
  input  logic            mosi_i,
  input  logic            ss_n_i,
  output logic            miso_o,
  output logic            miso_oe_o,
  input  logic [BITS-1:0] tx_data_i,
  input  logic            tx_load_i,
  output logic [BITS-1:0] rx_data_o,
  output logic            rx_full_o,
  input  logic            rx_read_i,
  output logic            ovr_o,
  input  logic            ovr_clr_i,
  output logic            modf_o,
  input  logic            modf_clr_i
);
  logic [1:0]      dat_s;
  logic            sck_s;
  logic            mosi_s;
  logic            ss_sync;
  logic            capture_ev;
  logic            launch_ev;
  logic            ss_fall_ev;
  logic            ss_rise_ev;
  logic            byte_done_ev;
  logic [BITS-1:0] byte_val;
  logic            abort_ev;
  logic [CW-1:0]   bit_cnt;
  logic            armed;
  logic [BITS-1:0] tx_hold;
  logic            full_eff;
  logic            accept_ev;
  logic            overrun_ev;
  logic            fault_ev;

  spi_slv_sync #(.W(2), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d_i({sck_i, mosi_i}), .q_o(dat_s)
  );
  assign sck_s  = dat_s[1];
  assign mosi_s = dat_s[0];

  spi_slv_sync #(.W(1), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d_i(ss_n_i), .q_o(ss_sync)
  );

  spi_slv_edges u_edges (
    .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sck_s(sck_s), .ss_s(ss_sync),
    .capture_ev(capture_ev), .launch_ev(launch_ev),
    .ss_fall_ev(ss_fall_ev), .ss_rise_ev(ss_rise_ev)
  );

  spi_slv_core #(.BITS(BITS)) u_core (
    .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha),
    .capture_ev(capture_ev), .launch_ev(launch_ev),
    .ss_fall_ev(ss_fall_ev), .ss_rise_ev(ss_rise_ev),
    .mosi_s(mosi_s), .tx_word(tx_hold),
    .miso(miso_o), .byte_done_ev(byte_done_ev), .byte_val(byte_val),
    .abort_ev(abort_ev), .bit_cnt(bit_cnt), .armed(armed)
  );

  assign miso_oe_o  = ~ss_sync;
  assign full_eff   = rx_full_o & ~rx_read_i;
  assign accept_ev  = byte_done_ev & ~full_eff;
  assign overrun_ev = byte_done_ev & full_eff;
  assign fault_ev   = abort_ev & cfg_fault_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold   <= '0;
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
      ovr_o     <= 1'b0;
      modf_o    <= 1'b0;
    end else begin
      if (tx_load_i) tx_hold <= tx_data_i;
      if (accept_ev) rx_data_o <= byte_val;
      rx_full_o <= accept_ev | full_eff;
      ovr_o     <= overrun_ev | (ovr_o & ~ovr_clr_i);
      modf_o    <= fault_ev | (modf_o & ~modf_clr_i);
    end
  end
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk #(
  parameter int BITS = 8,
  localparam int CW  = (BITS > 2) ? $clog2(BITS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_fault_en,
  input logic            ss_n_i,
  input logic            miso_oe_o,
  input logic [BITS-1:0] rx_data_o,
  input logic            rx_full_o,
  input logic            rx_read_i,
  input logic            ovr_o,
  input logic            modf_o,
  input logic            modf_clr_i,
  input logic            ss_sync,
  input logic            byte_done_ev,
  input logic [BITS-1:0] byte_val,
  input logic            abort_ev,
  input logic [CW-1:0]   bit_cnt
);
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ss_n_i, 1) && $past(ss_n_i, 2)) |-> !miso_oe_o); // R6
  AST_NO_BYTE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_sync |-> !byte_done_ev); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(BITS - 1)); // R1
  AST_ABORT_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (bit_cnt == '0)); // R7
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && cfg_fault_en) |=> modf_o); // R8
  AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fault_en && !modf_o) |=> !modf_o); // R8
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (modf_clr_i && !(abort_ev && cfg_fault_en)) |=> !modf_o); // R8
  AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_ev && !rx_full_o) |=> (rx_full_o && rx_data_o == $past(byte_val))); // R9
  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_ev && rx_full_o && !rx_read_i) |=> (ovr_o && $stable(rx_data_o))); // R10
endmodule

bind spi_slave_port spi_slave_port_chk #(.BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fault_en(cfg_fault_en), .ss_n_i(ss_n_i),
  .miso_oe_o(miso_oe_o), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
  .rx_read_i(rx_read_i), .ovr_o(ovr_o), .modf_o(modf_o), .modf_clr_i(modf_clr_i),
  .ss_sync(ss_sync), .byte_done_ev(byte_done_ev), .byte_val(byte_val),
  .abort_ev(abort_ev), .bit_cnt(bit_cnt)
);

// File: tb/spi_slave_port_bench.sv
module spi_slave_port_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, fen = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic miso_o, miso_oe_o;
  logic [7:0] tx_data = '0;
  logic tx_load = 1'b0;
  logic [7:0] rx_data_o;
  logic rx_full_o, ovr_o, modf_o;
  logic rx_read = 1'b0, ovr_clr = 1'b0, modf_clr = 1'b0;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_slave_port u_spi_slave_port (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_fault_en(fen),
    .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
    .rx_read_i(rx_read), .ovr_o(ovr_o), .ovr_clr_i(ovr_clr), .modf_o(modf_o),
    .modf_clr_i(modf_clr)
  );

  // master-side model: bit i of a frame, MSB first
  function automatic logic bit_at(input logic [7:0] v, input int i);
    return v[7 - i];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic load_tx(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic sel_low();
    @(negedge clk); sck = cpol;
    wait_clk(4); ss_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_high();
    @(negedge clk); ss_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic frame(input logic [7:0] mt, input int nbits, output logic [7:0] got);
    got = '0;
    if (!cpha) begin
      mosi = bit_at(mt, 0);
      for (int i = 0; i < nbits; i++) begin
        wait_clk(HALF); sck = ~cpol; got = {got[6:0], miso_o};
        wait_clk(HALF); sck = cpol;
        if (i < 7) mosi = bit_at(mt, i + 1);
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        wait_clk(HALF); sck = ~cpol; mosi = bit_at(mt, i);
        wait_clk(HALF); sck = cpol; got = {got[6:0], miso_o};
      end
    end
    wait_clk(HALF);
  endtask

  task automatic xfer_check(input logic [7:0] mt, input logic [7:0] st, input string req);
    logic [7:0] got;
    load_tx(st);
    sel_low();
    frame(mt, 8, got);
    sel_high();
    check(rx_full_o === 1'b1, req, rx_full_o, 1);
    check(rx_data_o === mt, req, rx_data_o, mt);
    check(got === st, req, got, st);
    pulse(rx_read);
    wait_clk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    int unsigned seed;
    seed = 32'd5471;
    void'($urandom(seed));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);

    // R12 reset state
    check(miso_oe_o === 1'b0, "R12 oe", miso_oe_o, 0);
    check(rx_full_o === 1'b0, "R12 full", rx_full_o, 0);
    check(ovr_o === 1'b0 && modf_o === 1'b0, "R12 flags", {ovr_o, modf_o}, 0);
    check(rx_data_o === 8'h00, "R12 data", rx_data_o, 0);

    // R2 all four clock modes with fixed patterns
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      xfer_check(8'hA5 ^ 8'(m), 8'h3C + 8'(m), "R2 mode");
    end

    // R3 first outgoing bit before any clock edge, phase 0
    cpol = 1'b0; cpha = 1'b0;
    load_tx(8'h81);
    sel_low();
    check(miso_oe_o === 1'b1, "R3 oe", miso_oe_o, 1);
    check(miso_o === 1'b1, "R3 msb", miso_o, 1);
    frame(8'h5A, 8, g);
    check(g === 8'h81, "R3 byte", g, 8'h81);
    wait_clk(4);
    pulse(rx_read);
    // R4 second byte without select toggle is ignored
    frame(8'hC3, 8, g);
    wait_clk(6);
    check(rx_full_o === 1'b0, "R4 no byte", rx_full_o, 0);
    check(rx_data_o === 8'h5A, "R4 data kept", rx_data_o, 8'h5A);
    sel_high();
    check(miso_oe_o === 1'b0, "R6 oe off", miso_oe_o, 0);

    // R6 clocks while deselected change nothing
    frame(8'hFF, 8, g);
    wait_clk(6);
    check(rx_full_o === 1'b0, "R6 no rx", rx_full_o, 0);
    check(modf_o === 1'b0, "R6 no fault", modf_o, 0);

    // R5 / R11 phase 1 back-to-back bytes under one select
    cpha = 1'b1;
    load_tx(8'h11);
    sel_low();
    frame(8'h96, 8, g);
    wait_clk(4);
    check(rx_data_o === 8'h96 && rx_full_o === 1'b1, "R5 byte1", rx_data_o, 8'h96);
    check(g === 8'h11, "R5 tx1", g, 8'h11);
    pulse(rx_read);
    load_tx(8'hE7);
    frame(8'h0F, 8, g);
    wait_clk(4);
    check(rx_data_o === 8'h0F && rx_full_o === 1'b1, "R5 byte2", rx_data_o, 8'h0F);
    check(g === 8'hE7, "R11 tx2", g, 8'hE7);
    pulse(rx_read);
    frame(8'hF0, 8, g);
    wait_clk(4);
    check(rx_data_o === 8'hF0, "R5 byte3", rx_data_o, 8'hF0);
    check(g === 8'hE7, "R11 resend", g, 8'hE7);
    pulse(rx_read);
    sel_high();

    // R7 / R8 abort after three bits with fault detection on
    cpha = 1'b0; fen = 1'b1;
    load_tx(8'h42);
    sel_low();
    frame(8'hFF, 3, g);
    sel_high();
    check(modf_o === 1'b1, "R8 fault set", modf_o, 1);
    check(rx_full_o === 1'b0, "R7 partial dropped", rx_full_o, 0);
    pulse(modf_clr);
    wait_clk(1);
    check(modf_o === 1'b0, "R8 fault cleared", modf_o, 0);
    xfer_check(8'h24, 8'h42, "R7 next byte");
    // R8 masked
    fen = 1'b0; cpha = 1'b1;
    sel_low();
    frame(8'h00, 5, g);
    sel_high();
    check(modf_o === 1'b0, "R8 masked", modf_o, 0);
    xfer_check(8'hB1, 8'h7E, "R7 phase1 next byte");
    fen = 1'b1;

    // R9 / R10 overrun: two bytes, no read between
    cpha = 1'b0;
    load_tx(8'h00);
    sel_low(); frame(8'h6D, 8, g); sel_high();
    check(rx_full_o === 1'b1 && ovr_o === 1'b0, "R9 full", rx_full_o, 1);
    sel_low(); frame(8'h92, 8, g); sel_high();
    check(ovr_o === 1'b1, "R10 ovr set", ovr_o, 1);
    check(rx_data_o === 8'h6D, "R10 data kept", rx_data_o, 8'h6D);
    pulse(rx_read);
    wait_clk(1);
    check(rx_full_o === 1'b0, "R9 read clears", rx_full_o, 0);
    pulse(ovr_clr);
    wait_clk(1);
    check(ovr_o === 1'b0, "R10 ovr cleared", ovr_o, 0);

    // R1 random bytes in random modes
    for (int k = 0; k < 40; k++) begin
      cpol = 1'($urandom);
      cpha = 1'($urandom);
      xfer_check(8'($urandom), 8'($urandom), "R1 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule